// File: doc/BRIEF.md
# Double-Late-Write Pipelined Synchronous SRAM Core

This block is a small synchronous, single-data-rate memory with the timing of a fast networking SRAM. One command is accepted per clock: an address, a write flag, a burst-continue flag, per-lane byte enables and three chip-enable inputs. Read data leaves through an output register two clocks after the command. Write data follows its command by two clocks (double late write), so the core keeps the last two write commands in a pending buffer until their data arrives.

A read that targets an address still in that buffer returns the newest data. The buffered bytes are merged lane by lane over the array contents. Bursts continue from an internal address whose two low bits count upward and wrap. The usual bidirectional data bus is split into an input bus, an output bus and an output-enable, which a pad ring or an on-chip bus can combine.

Two of the chip enables have an active level set by a strap input each. Several instances can therefore share one bus and be told apart by address decode.

Top module: `dlwSram`

## Requirements
- R1: After reset `dataOe` is 0, `dataOut` is all zeros and every array word reads back as zero.
- R2: A read command registered at clock edge j drives its word on `dataOut` with `dataOe` = 1 from edge j+2 until edge j+3. In every cycle without read data, `dataOe` is 0 and `dataOut` is zero.
- R3: A write command registered at edge j takes its data from `dataIn` at edge j+2 and stores it in the array at that edge. `dataIn` at any other edge is not stored.
- R4: `byteEn[i]` = 1 lets a write change lane i, which is bits [9i+8:9i]. Lanes whose enable is 0 keep their old value. `byteEn` has no effect on reads.
- R5: A read returns every write whose command came earlier, including writes whose data has not reached the array when the read is registered. This holds for one or two pending writes, merged lane by lane.
- R6: When two pending writes hit the same address, the lanes of the later write win both in the array and in a read that follows them.
- R7: With `advIn` = 1 after a selected command or burst beat, the block repeats the previous operation type at the previous address with its two low bits incremented modulo 4 and the upper bits kept. `addrIn`, `cmdWrite` and the chip enables are ignored in that cycle.
- R8: With `advIn` = 1 when no burst is live (the last non-advance cycle was deselected), the cycle is a no-operation.
- R9: A non-advance cycle is selected only when `csMain` = 1, `csExtA` equals `polExtA` and `csExtB` equals `polExtB`. An unselected cycle neither reads nor writes.
- R10: Deselected cycles still advance the pipelines. Pending writes complete two edges after their command, and the output stays enabled for a read already in flight before it turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset (array cleared synchronously) |
| addrIn | input | ADDR_W | Word address of a non-advance command |
| cmdWrite | input | 1 | 1 = write, 0 = read, for a non-advance command |
| advIn | input | 1 | 1 = continue the live burst with the internal address |
| byteEn | input | LANES | Per-lane write enables, active high |
| csMain | input | 1 | Primary chip enable, active high |
| csExtA | input | 1 | Expansion enable A, active level set by polExtA |
| csExtB | input | 1 | Expansion enable B, active level set by polExtB |
| polExtA | input | 1 | Strap: level of csExtA that selects |
| polExtB | input | 1 | Strap: level of csExtB that selects |
| dataIn | input | DATA_W | Write data, sampled two edges after the write command |
| dataOut | output | DATA_W | Registered read data, zero when not enabled |
| dataOe | output | 1 | High only while dataOut carries read data |

## Verification
The assertions check several rules on every cycle:
- a write command is followed two edges later by a commit to the same address;
- a burst step increments only the two low address bits;
- an unselected non-advance cycle launches nothing;
- the output-enable follows the read pipeline exactly, with quiet zeros in between.

Only the bench scenarios, checked against a behavioural model, can show that the data itself is right. That covers merging from one or two pending writes, newest-wins ordering, lane masking, wrapping burst order, strap polarity and writes finishing under deselect.

// File: rtl/dlwSramPkg.sv
package dlwSramPkg;

  // Strobes from the control to the datapath, one bundle per cycle.
  typedef struct packed {
    logic doRead;     // capture array word (with early merge) this edge
    logic lateMerge;  // apply second-stage merge this edge
    logic outLoad;    // load output register with read data this edge
    logic commitEn;   // store dataIn into the array this edge
  } dpStrobe_t;

endpackage

// File: rtl/dlwSramCtrl.sv
module dlwSramCtrl
  import dlwSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cmdWrite,
  input  logic              advIn,
  input  logic [LANES-1:0]  byteEn,
  input  logic              csMain,
  input  logic              csExtA,
  input  logic              csExtB,
  input  logic              polExtA,
  input  logic              polExtB,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LANES-1:0]  fwdNowMask,
  output logic [LANES-1:0]  fwdLateMask,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [LANES-1:0]  commitMask
);

  localparam int WRAP_W = 2;

  // command decode
  logic              selected;
  logic              opValid;
  logic              opWrite;
  logic [ADDR_W-1:0] opAddr;

  // burst state
  logic              burstLive;
  logic              burstWrite;
  logic [ADDR_W-1:0] curAddr;

  // pending write stages (stage 1 newest)
  logic              st1V, st2V;
  logic [ADDR_W-1:0] st1Addr, st2Addr;
  logic [LANES-1:0]  st1Be, st2Be;

  // read pipeline
  logic              rdV1, rdV2;
  logic [ADDR_W-1:0] rdAddrQ;

  assign selected = csMain && (csExtA == polExtA) && (csExtB == polExtB);

  always_comb begin
    if (advIn) begin
      opValid = burstLive;
      opWrite = burstWrite;
      opAddr  = {curAddr[ADDR_W-1:WRAP_W], curAddr[WRAP_W-1:0] + 2'd1};
    end else begin
      opValid = selected;
      opWrite = cmdWrite;
      opAddr  = addrIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLive  <= 1'b0;
      burstWrite <= 1'b0;
      curAddr    <= '0;
    end else begin
      if (!advIn) begin
        burstLive <= selected;
        if (selected) burstWrite <= cmdWrite;
      end
      if (opValid) curAddr <= opAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st1V    <= 1'b0;
      st1Addr <= '0;
      st1Be   <= '0;
      st2V    <= 1'b0;
      st2Addr <= '0;
      st2Be   <= '0;
      rdV1    <= 1'b0;
      rdV2    <= 1'b0;
      rdAddrQ <= '0;
    end else begin
      st1V    <= opValid && opWrite;
      st1Addr <= opAddr;
      st1Be   <= byteEn;
      st2V    <= st1V;
      st2Addr <= st1Addr;
      st2Be   <= st1Be;
      rdV1    <= opValid && !opWrite;
      rdAddrQ <= opAddr;
      rdV2    <= rdV1;
    end
  end

  // Stage 2 commits this edge: its lanes merge into a read captured now.
  // Stage 1 commits next edge: its lanes merge one edge later, on top.
  always_comb begin
    stb.doRead    = opValid && !opWrite;
    stb.lateMerge = rdV1;
    stb.outLoad   = rdV2;
    stb.commitEn  = st2V;
    rdAddr        = opAddr;
    commitAddr    = st2Addr;
    commitMask    = st2Be;
    fwdNowMask    = (st2V && (st2Addr == opAddr)) ? st2Be : '0;
    fwdLateMask   = (st2V && rdV1 && (st2Addr == rdAddrQ)) ? st2Be : '0;
  end

  AST_WRITE_COMMIT_LATE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opWrite) |-> ##2 (stb.commitEn && commitAddr == $past(opAddr, 2))); // R3

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (advIn && burstLive) |=> (curAddr[WRAP_W-1:0] == $past(curAddr[WRAP_W-1:0]) + 2'd1
                              && curAddr[ADDR_W-1:WRAP_W] == $past(curAddr[ADDR_W-1:WRAP_W]))); // R7

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!advIn && !selected) |=> (!rdV1 && !st1V)); // R9

  AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (advIn && !burstLive) |=> (!rdV1 && !st1V)); // R8

endmodule

// File: rtl/dlwSramDatapath.sv
module dlwSramDatapath
  import dlwSramPkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  stb,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  logic [LANES-1:0]           fwdNowMask,
  input  logic [LANES-1:0]           fwdLateMask,
  input  logic [$clog2(DEPTH)-1:0]   commitAddr,
  input  logic [LANES-1:0]           commitMask,
  input  logic [LANES*LANE_BITS-1:0] dataIn,
  output logic [LANES*LANE_BITS-1:0] dataOut,
  output logic                       dataOe
);

  localparam int DATA_W = LANES * LANE_BITS;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] memWord;
  logic [DATA_W-1:0] nowMerged;
  logic [DATA_W-1:0] lateMerged;
  logic [DATA_W-1:0] rdHold1;
  logic [DATA_W-1:0] rdHold2;

  assign memWord = memArr[rdAddr];

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign nowMerged[l*LANE_BITS +: LANE_BITS] =
      fwdNowMask[l] ? dataIn[l*LANE_BITS +: LANE_BITS] : memWord[l*LANE_BITS +: LANE_BITS];
    assign lateMerged[l*LANE_BITS +: LANE_BITS] =
      fwdLateMask[l] ? dataIn[l*LANE_BITS +: LANE_BITS] : rdHold1[l*LANE_BITS +: LANE_BITS];
  end

  // Array: cleared while reset is held, then byte-lane commits.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (stb.commitEn) begin
      for (int l = 0; l < LANES; l++)
        if (commitMask[l]) memArr[commitAddr][l*LANE_BITS +: LANE_BITS] <= dataIn[l*LANE_BITS +: LANE_BITS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHold1 <= '0;
      rdHold2 <= '0;
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      if (stb.doRead)    rdHold1 <= nowMerged;
      if (stb.lateMerge) rdHold2 <= lateMerged;
      dataOut <= stb.outLoad ? rdHold2 : '0;
      dataOe  <= stb.outLoad;
    end
  end

  AST_OE_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    stb.outLoad |=> dataOe); // R2

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stb.outLoad |=> (!dataOe && dataOut == '0)); // R2

  AST_READ_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    stb.lateMerge |=> ##1 dataOe); // R10

endmodule

// File: rtl/dlwSram.sv
module dlwSram
  import dlwSramPkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int DATA_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cmdWrite,
  input  logic              advIn,
  input  logic [LANES-1:0]  byteEn,
  input  logic              csMain,
  input  logic              csExtA,
  input  logic              csExtB,
  input  logic              polExtA,
  input  logic              polExtB,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  dpStrobe_t         stb;
  logic [ADDR_W-1:0] rdAddr;
  logic [LANES-1:0]  fwdNowMask;
  logic [LANES-1:0]  fwdLateMask;
  logic [ADDR_W-1:0] commitAddr;
  logic [LANES-1:0]  commitMask;

  dlwSramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .cmdWrite(cmdWrite), .advIn(advIn),
    .byteEn(byteEn), .csMain(csMain), .csExtA(csExtA), .csExtB(csExtB),
    .polExtA(polExtA), .polExtB(polExtB), .stb(stb), .rdAddr(rdAddr),
    .fwdNowMask(fwdNowMask), .fwdLateMask(fwdLateMask),
    .commitAddr(commitAddr), .commitMask(commitMask)
  );

  dlwSramDatapath #(.DEPTH(DEPTH), .LANES(LANES), .LANE_BITS(LANE_BITS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr),
    .fwdNowMask(fwdNowMask), .fwdLateMask(fwdLateMask),
    .commitAddr(commitAddr), .commitMask(commitMask),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/dlwSram_test.sv
module dlwSram_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addrIn = '0;
  logic        cmdWrite = 1'b0;
  logic        advIn = 1'b0;
  logic [3:0]  byteEn = '0;
  logic        csMain = 1'b0;
  logic        csExtA = 1'b1;
  logic        csExtB = 1'b1;
  logic        polExtA = 1'b1;
  logic        polExtB = 1'b1;
  logic [35:0] dataIn = '0;
  logic [35:0] dataOut;
  logic        dataOe;

  always #4 clk = ~clk;

  dlwSram uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .cmdWrite(cmdWrite), .advIn(advIn),
    .byteEn(byteEn), .csMain(csMain), .csExtA(csExtA), .csExtB(csExtB),
    .polExtA(polExtA), .polExtB(polExtB), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // behavioural reference
  int          t = 0;
  logic [35:0] mMem [64];
  int          rdAt [int];
  logic [9:0]  wrAt [int];
  logic [35:0] sched [int];
  bit          mLive = 0, mWrite = 0;
  logic [5:0]  mAddr = '0;
  logic        expOe = 1'b0;
  logic [35:0] expOut = '0;

  task automatic modelEdge();
    bit v, w, sel;
    logic [5:0] a;
    expOe  = rdAt.exists(t);
    expOut = expOe ? mMem[rdAt[t]] : '0;
    if (expOe) rdAt.delete(t);
    if (wrAt.exists(t)) begin
      for (int l = 0; l < 4; l++)
        if (wrAt[t][l]) mMem[wrAt[t][9:4]][l*9 +: 9] = dataIn[l*9 +: 9];
      wrAt.delete(t);
    end
    sel = csMain && (csExtA == polExtA) && (csExtB == polExtB);
    if (advIn) begin
      v = mLive; w = mWrite; a = {mAddr[5:2], mAddr[1:0] + 2'd1};
    end else begin
      v = sel; w = cmdWrite; a = addrIn;
      mLive = sel;
      if (sel) mWrite = cmdWrite;
    end
    if (v) begin
      mAddr = a;
      if (w) wrAt[t+2] = {a, byteEn};
      else   rdAt[t+2] = a;
    end
    t++;
  endtask

  task automatic check();
    checks++;
    if (dataOe !== expOe || dataOut !== expOut) begin
      errors++;
      $display("FAIL %s: cycle %0d oe=%0b out=%h expected oe=%0b out=%h",
               curReq, t, dataOe, dataOut, expOe, expOut);
    end
  endtask

  task automatic cyc(bit cs, bit wr, bit adv, logic [5:0] a, logic [3:0] be);
    check();
    csMain = cs; cmdWrite = wr; advIn = adv; addrIn = a; byteEn = be;
    dataIn = sched.exists(t) ? sched[t] : (36'h9_5A5A_5A5A ^ 36'(t * 7919));
    modelEdge();
    @(negedge clk);
  endtask

  task automatic wrt(logic [5:0] a, logic [3:0] be, logic [35:0] d);
    sched[t+2] = d;
    cyc(1, 1, 0, a, be);
  endtask

  task automatic rd(logic [5:0] a);
    cyc(1, 0, 0, a, 4'h0);
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 6'h3F, 4'hF);
  endtask

  // advance beat: address, write flag and selects driven as junk
  task automatic adv(logic [35:0] d);
    sched[t+2] = d;
    cyc(0, 1, 1, 6'h2A, 4'hF);
  endtask

  bit done = 0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset outputs and cleared array
    curReq = "R1";
    nop(2);
    rd(6'h00); rd(6'h05); rd(6'h3F);
    nop(3);

    // R2 / R3: plain write then read, latency and late data
    curReq = "R3";
    wrt(6'h0A, 4'hF, 36'hA_BCDE_F012);
    nop(3);
    curReq = "R2";
    rd(6'h0A); nop(1); rd(6'h0A); rd(6'h0A); nop(3);

    // R4: byte-lane writes
    curReq = "R4";
    wrt(6'h11, 4'hF, 36'h1_1111_1111);
    nop(2);
    wrt(6'h11, 4'b0101, 36'hE_EEEE_EEEE);
    nop(2);
    wrt(6'h11, 4'b1000, 36'h7_7700_0000);
    nop(2);
    rd(6'h11); nop(3);

    // R5: read right after write (one pending), after a gap, two pending
    curReq = "R5";
    wrt(6'h20, 4'b0011, 36'h3_3333_3333);
    rd(6'h20);
    wrt(6'h21, 4'hF, 36'h4_4444_4444);
    nop(1);
    rd(6'h21);
    wrt(6'h22, 4'b1100, 36'hC_CCCC_CCCC);
    wrt(6'h22, 4'b0110, 36'h6_6666_6666);
    rd(6'h22);
    nop(3);

    // R6: newer write wins on overlapping lanes
    curReq = "R6";
    wrt(6'h30, 4'hF, 36'h0_1234_5678);
    wrt(6'h30, 4'b0011, 36'hF_FFFF_FFFF);
    rd(6'h30);
    nop(3);
    rd(6'h30); nop(3);

    // R7: write burst with wrap, then read burst with wrap
    curReq = "R7";
    wrt(6'h0E, 4'hF, 36'h1_0000_000E);
    adv(36'h1_0000_000F);
    adv(36'h1_0000_000C);
    adv(36'h1_0000_000D);
    nop(2);
    rd(6'h0F);
    adv('0); adv('0); adv('0); adv('0);
    nop(3);

    // R8: advance with no live burst is a no-op
    curReq = "R8";
    nop(1);
    adv(36'hD_EAD0_BEEF);
    adv(36'hD_EAD0_BEEF);
    nop(3);
    rd(6'h2B); rd(6'h2C); nop(3);

    // R9: select decoding and strap polarity
    curReq = "R9";
    csExtA = 1'b0;
    wrt(6'h05, 4'hF, 36'hB_AD00_0005);
    rd(6'h0A);
    nop(3);
    polExtA = 1'b0;
    wrt(6'h06, 4'hF, 36'h6_0000_0006);
    csExtB = 1'b0;
    rd(6'h06);
    nop(2);
    csExtB = 1'b1;
    rd(6'h06); rd(6'h05);
    csExtA = 1'b1; polExtA = 1'b1;
    nop(3);

    // R10: deselect lets writes finish and in-flight read drain
    curReq = "R10";
    wrt(6'h3A, 4'hF, 36'h5_0000_003A);
    rd(6'h3A);
    nop(4);
    rd(6'h3A);
    nop(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule